// File: doc/BRIEF.md
# Accumulator Sign-Run Normalizer

This block normalizes a signed 36-bit accumulator in one pass. It does not step the value one bit at a time. The 32-bit field below the four extension bits is scanned from bit 31 downward. The block counts how many bits in a row match bit 31: zeros for a non-negative field, ones for a negative field. One less than that run length is the left-shift amount. The field is then shifted left by that amount, filling with zeros from the bottom. After the shift, the first magnitude bit sits at bit 30, just under the sign. The four upper bits of the result are copies of the new bit 31.

The extension bits of the input are never examined. A value that already reaches into the extension therefore falls outside the supported range. Such a value is normalized as if only its low 32 bits existed. A caller presents an accumulator together with a one-cycle valid strobe. On the next clock the registered shift amount and normalized accumulator appear, together with a one-cycle result strobe. The shift amount can later be used to scale the value back to its original magnitude.

A two-state controller sequences the output strobe. In state `ST_IDLE` no result is being presented. In state `ST_SHOW` the registered result is flagged valid. The transitions are as follows:
- IDLE→SHOW when a valid input arrives.
- SHOW→SHOW when another valid input follows at once.
- SHOW→IDLE when the input strobe is low.
- IDLE→IDLE when no input arrives.

Top module: `acc_normalizer`

## Requirements
- R1: After reset, `res_valid` is 0, `res_shift` is 0 and `res_acc` is 0.
- R2: `res_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1, and 0 otherwise.
- R3: `res_shift` equals the number of consecutive bits, counted from bit 31 of `in_acc` downward and including bit 31, that equal bit 31, minus one. It lies in the range 0 to 31.
- R4: Bits [35:32] of `in_acc` have no effect on `res_shift` or `res_acc`.
- R5: `res_acc[31:0]` equals `in_acc[31:0]` shifted left by `res_shift`, with zeros entering at bit 0.
- R6: `res_acc[35:32]` are all equal to `res_acc[31]`.
- R7: In every valid result, `res_acc[30]` differs from `res_acc[31]` unless `res_acc[31:0]` is zero.
- R8: An input field of all zeros or all ones gives `res_shift` = 31. The results are 0 and 0xF80000000 respectively.
- R9: While `in_valid` is 0, `res_shift` and `res_acc` keep their last values, whatever `in_acc` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input accumulator present this cycle |
| in_acc | input | 36 | Accumulator to normalize (bits [35:32] ignored) |
| res_valid | output | 1 | Result presented this cycle |
| res_shift | output | 5 | Left-shift amount applied (leading sign bits minus one) |
| res_acc | output | 36 | Normalized accumulator |

## Verification
Every result of this block, the strobe, the shift amount and the normalized value, is due on the first clock edge after the input strobe. There is one register stage and no other latency. The bench drives each input half a cycle before an edge and reads the outputs at the falling edge that follows. This includes back-to-back strobes, where each result is read before the next input is applied. The hold behaviour is checked at the next falling edge after the input changes with the strobe low. At that point the strobe must be low and the result must still hold the earlier value.

// File: rtl/acc_norm_pkg.sv
package acc_norm_pkg;

    localparam int unsigned DEF_ACC_W = 36;
    localparam int unsigned DEF_EXT_W = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } norm_state_t;

endpackage

// File: rtl/sign_run_counter.sv
module sign_run_counter #(
    parameter int unsigned FIELD_W = 32,
    parameter int unsigned CNT_W   = $clog2(FIELD_W)
) (
    input  logic [FIELD_W-1:0] field,
    output logic [CNT_W-1:0]   run_less_one
);

    logic sign_bit;
    logic [FIELD_W-2:0] still_run;

    assign sign_bit = field[FIELD_W-1];

    // still_run[i] is set while every bit from FIELD_W-2 down to i matches the sign
    assign still_run[FIELD_W-2] = (field[FIELD_W-2] == sign_bit);

    generate
        for (genvar i = FIELD_W - 3; i >= 0; i--) begin : g_chain
            assign still_run[i] = still_run[i+1] & (field[i] == sign_bit);
        end
    endgenerate

    always_comb begin
        run_less_one = '0;
        for (int i = 0; i < FIELD_W - 1; i++) begin
            run_less_one = run_less_one + CNT_W'(still_run[i]);
        end
    end

endmodule

// File: rtl/field_left_shifter.sv
module field_left_shifter #(
    parameter int unsigned FIELD_W = 32,
    parameter int unsigned CNT_W   = $clog2(FIELD_W)
) (
    input  logic [FIELD_W-1:0] din,
    input  logic [CNT_W-1:0]   amount,
    output logic [FIELD_W-1:0] dout
);

    logic [FIELD_W-1:0] stage [CNT_W+1];

    assign stage[0] = din;

    generate
        for (genvar s = 0; s < CNT_W; s++) begin : g_stage
            assign stage[s+1] = amount[s] ? (stage[s] << (1 << s)) : stage[s];
        end
    endgenerate

    assign dout = stage[CNT_W];

endmodule

// File: rtl/acc_normalizer.sv
module acc_normalizer
    import acc_norm_pkg::*;
#(
    parameter int unsigned ACC_W   = DEF_ACC_W,
    parameter int unsigned EXT_W   = DEF_EXT_W,
    parameter int unsigned FIELD_W = ACC_W - EXT_W,
    parameter int unsigned CNT_W   = $clog2(FIELD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ACC_W-1:0]   in_acc,
    output logic               res_valid,
    output logic [CNT_W-1:0]   res_shift,
    output logic [ACC_W-1:0]   res_acc
);

    norm_state_t state_q, state_d;

    logic [FIELD_W-1:0] field;
    logic [CNT_W-1:0]   run_amt;
    logic [FIELD_W-1:0] shifted;
    logic [ACC_W-1:0]   norm_next;

    assign field = in_acc[FIELD_W-1:0];

    sign_run_counter #(
        .FIELD_W (FIELD_W),
        .CNT_W   (CNT_W)
    ) u_count (
        .field        (field),
        .run_less_one (run_amt)
    );

    field_left_shifter #(
        .FIELD_W (FIELD_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .din    (field),
        .amount (run_amt),
        .dout   (shifted)
    );

    assign norm_next = {{EXT_W{shifted[FIELD_W-1]}}, shifted};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: res_valid = 1'b0;
            ST_SHOW: res_valid = 1'b1;
            default: res_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_shift <= '0;
            res_acc   <= '0;
        end else if (in_valid) begin
            res_shift <= run_amt;
            res_acc   <= norm_next;
        end
    end

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    assert_strobe_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    assert_input_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !$isunknown(in_acc));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_acc) && $stable(res_shift)));

    assert_ext_copies_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_acc[ACC_W-1:FIELD_W] == {EXT_W{res_acc[FIELD_W-1]}}));

    assert_msb_at_thirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_acc[FIELD_W-1] != res_acc[FIELD_W-2]) || (res_acc[FIELD_W-1:0] == '0)));

endmodule

// File: tb/acc_normalizer_tb.sv
module acc_normalizer_tb;

    localparam int ACC_W = 36;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [ACC_W-1:0] in_acc = '0;
    logic             res_valid;
    logic [CNT_W-1:0] res_shift;
    logic [ACC_W-1:0] res_acc;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    acc_normalizer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_acc    (in_acc),
        .res_valid (res_valid),
        .res_shift (res_shift),
        .res_acc   (res_acc)
    );

    function automatic int model_shift(input logic [31:0] f);
        int n = 0;
        bit run = 1;
        for (int i = 30; i >= 0; i--) begin
            if (run && f[i] == f[31]) n++;
            else run = 0;
        end
        return n;
    endfunction

    function automatic logic [ACC_W-1:0] model_norm(input logic [31:0] f);
        logic [31:0] s;
        s = f << model_shift(f);
        return {{4{s[31]}}, s};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one input, check the result one edge later
    task automatic apply(input logic [ACC_W-1:0] a, input string tag);
        @(negedge clk);
        in_acc = a;
        in_valid = 1'b1;
        @(negedge clk);
        chk({tag, " R2 valid"}, 64'(res_valid), 64'd1);
        chk({tag, " R3 shift"}, 64'(res_shift), 64'(model_shift(a[31:0])));
        chk({tag, " R5 R6 acc"}, 64'(res_acc), 64'(model_norm(a[31:0])));
        in_valid = 1'b0;
    endtask

    initial begin
        logic [ACC_W-1:0] a;
        logic [ACC_W-1:0] held;
        logic [CNT_W-1:0] held_s;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 valid", 64'(res_valid), 64'd0);
        chk("R1 shift", 64'(res_shift), 64'd0);
        chk("R1 acc", 64'(res_acc), 64'd0);
        rst_n = 1'b1;

        // R8 corner cases
        apply(36'h0_0000_0000, "R8 zeros");
        chk("R8 zeros shift", 64'(res_shift), 64'd31);
        apply(36'hF_FFFF_FFFF, "R8 ones");
        chk("R8 ones acc", 64'(res_acc), 64'hF_8000_0000);
        apply(36'h0_4000_0000, "R3 already normal");
        chk("R3 zero shift", 64'(res_shift), 64'd0);
        apply(36'h0_0000_0001, "R3 lsb only");
        chk("R7 lsb acc", 64'(res_acc), 64'h0_4000_0000);
        apply(36'hF_FFFF_FFFE, "R3 neg small");
        apply(36'h0_8000_0000, "R3 min neg");

        // R4: extension bits ignored
        for (int k = 0; k < 20; k++) begin
            a = {$urandom, $urandom};
            apply({a[35:32], 32'h0001_2345}, "R4 ext");
            chk("R4 ext shift", 64'(res_shift), 64'd14);
        end

        // random with random-length sign runs
        for (int k = 0; k < 300; k++) begin
            logic [31:0] f;
            f = $urandom;
            f = f >>> ($urandom % 32);
            if ($urandom % 2) f = ~f;
            a = {4'($urandom), f};
            apply(a, "R3 R5 random");
        end

        // back-to-back strobes
        @(negedge clk);
        in_acc = 36'h0_0000_00F0; in_valid = 1'b1;
        @(negedge clk);
        chk("R2 b2b first", 64'(res_shift), 64'd23);
        in_acc = 36'h0_FFFF_0000;
        @(negedge clk);
        chk("R2 b2b valid", 64'(res_valid), 64'd1);
        chk("R2 b2b second", 64'(res_shift), 64'd15);
        chk("R2 b2b acc", 64'(res_acc), 64'hF_8000_0000);
        in_valid = 1'b0;

        // R9 hold
        held = res_acc; held_s = res_shift;
        in_acc = 36'h0_0000_0003;
        @(negedge clk);
        chk("R2 idle valid", 64'(res_valid), 64'd0);
        chk("R9 hold acc", 64'(res_acc), 64'(held));
        chk("R9 hold shift", 64'(res_shift), 64'(held_s));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule